// File: doc/BRIEF.md
# Clock Loss and Lock Monitor

This block watches two clocks from a free-running monitor clock. One is a reference input and the other is the feedback clock of a PLL. Rising edges of each watched clock flip a toggle in that clock's own domain. A synchroniser carries the toggle into the monitor domain, where it becomes a single-cycle edge pulse. If the reference delivers no edge for a programmed number of monitor cycles, the block raises loss of signal. The flag drops once edges have been arriving steadily for a second, shorter programmed time.

During a counting window of fixed monitor-cycle length, the block counts the edges of both clocks. At the close of the window it compares the absolute count difference with a threshold. The threshold is scaled from the reference count and a programmed ratio. A window beyond the threshold raises loss of lock. Lock is granted only after a programmed run of consecutive windows within threshold. A calibration flag is shown for as long as lock is being acquired. A pause input freezes the loss-of-lock machine during reconfiguration. Releasing the pause starts acquisition again.

The flags are gathered into an 8-bit status byte. A second input supplies the crystal-loss flag. The status byte drives a maskable active-high interrupt, and the interrupt serves as the pull-down enable of an open-drain pin.

Top module: `clkmon_top`

## Requirements
- R1: While `rst` is high, `status` and `irq` are 0. After reset with both clocks running, `status[0]` (acquisition) reads 1 and `status[4]` reads 0.
- R2: The status byte layout is as follows.
  - Bit 4 is loss of lock.
  - Bit 3 is reference loss of signal.
  - Bit 2 is the registered `xtal_lost` input.
  - Bit 0 is acquisition in progress.
  - Bits 7:5 and bit 1 are always 0.
- R3: Reference loss (`status[3]`) rises only after the reference has had no rising edge for `LOS_SET_CYC` monitor cycles. The rise comes at most 8 cycles later than that, to allow for synchroniser and register latency.
- R4: While reference loss is set, the flag clears once reference edges have arrived with gaps shorter than `LOS_GAP` cycles for `LOS_CLR_CYC` consecutive cycles. It does not clear before that.
- R5: At the close of every `WIN_CYC`-cycle window, loss of lock (`status[4]`) is set when |ref_count − fb_count| > (ref_count × `thr`) >> 20. The threshold is therefore in parts per 2^20.
- R6: Lock is granted after `lock_win` consecutive good windows, with 0 treated as 1. At that point `status[4]` and `status[0]` both go to 0. A bad window while locked sets `status[4]` and restarts acquisition (`status[0]` = 1).
- R7: While `pause` is 1, `status[4]` holds its value, `status[0]` is 0 and no window is judged. After `pause` falls, `status[0]` returns to 1.
- R8: `irq` is 1 exactly when a status bit in [4:0] is set and its matching `int_mask` bit is 0. A mask bit of 1 blocks only the interrupt, and the status bit stays visible. `irq` is registered in the same cycle as `status`.
- R9: When not paused, reference loss forces `status[4]` = 1 and `status[0]` = 1. Once the reference returns, loss of lock clears after the required good windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Watched reference clock |
| fb_clk | input | 1 | Watched PLL feedback clock |
| xtal_lost | input | 1 | Crystal loss flag, monitor domain |
| pause | input | 1 | Freezes the loss-of-lock machine |
| thr | input | 16 | Lock threshold, parts per 2^20 |
| lock_win | input | 4 | Consecutive good windows needed for lock |
| int_mask | input | 5 | Interrupt mask, one bit per status bit [4:0] |
| status | output | 8 | Status byte |
| irq | output | 1 | Active-high interrupt and open-drain pull-down enable |

## Verification
Three coincidences matter: a pause request can land in the same cycle as a window close, reference loss can fall on a window boundary, and a mask change can coincide with a status change. The bench holds `pause` across several windows of badly mismatched clocks, so pause and window close are bound to meet. It then judges that loss of lock never moves and acquisition reads 0. The bench also stops the reference while windows keep closing and expects loss of signal to drive both loss of lock and acquisition. Finally, it changes the mask while the acquisition flag is active and judges `irq` against the status byte and the mask.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;
  localparam int STAT_W  = 8;
  localparam int B_LOL   = 4;
  localparam int B_LOS   = 3;
  localparam int B_XTAL  = 2;
  localparam int B_CAL   = 0;
  localparam int MASK_W  = 5;

  typedef enum logic [1:0] {
    ST_CAL  = 2'd0,
    ST_LOCK = 2'd1,
    ST_HOLD = 2'd2
  } lol_state_t;
endpackage

// File: rtl/clkmon_edge_sync.sv
`timescale 1ns/1ps
module clkmon_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic clk,
  input  logic rst,
  output logic edge_o
);
  logic tog_q = 1'b0;
  logic [STAGES:0] sync_q;

  always_ff @(posedge src_clk) tog_q <= ~tog_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-1:0], tog_q};
  end

  assign edge_o = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/clkmon_los.sv
`timescale 1ns/1ps
module clkmon_los #(
  parameter int LOS_SET_CYC = 260,
  parameter int LOS_CLR_CYC = 20,
  parameter int LOS_GAP     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic los_o
);
  localparam int IDLE_W = $clog2(LOS_SET_CYC + 1);
  localparam int ACT_W  = $clog2(LOS_CLR_CYC + 1);

  logic [IDLE_W-1:0] idle_q;
  logic [ACT_W-1:0]  act_q;
  logic              los_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= '0;
      act_q  <= '0;
      los_q  <= 1'b0;
    end else begin
      if (edge_i) idle_q <= '0;
      else if (idle_q != IDLE_W'(LOS_SET_CYC)) idle_q <= idle_q + IDLE_W'(1);

      if (!los_q) begin
        act_q <= '0;
        if (!edge_i && idle_q == IDLE_W'(LOS_SET_CYC - 1)) los_q <= 1'b1;
      end else if (idle_q >= IDLE_W'(LOS_GAP)) begin
        act_q <= '0;
      end else if (act_q == ACT_W'(LOS_CLR_CYC - 1)) begin
        act_q <= '0;
        los_q <= 1'b0;
      end else begin
        act_q <= act_q + ACT_W'(1);
      end
    end
  end

  assign los_o = los_q;

  p_los_rise_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(los_q) |-> !$past(edge_i));

  p_los_fall_active_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(los_q) |-> ($past(idle_q) < IDLE_W'(LOS_GAP)));
endmodule

// File: rtl/clkmon_lol.sv
`timescale 1ns/1ps
module clkmon_lol
  import clkmon_pkg::*;
#(
  parameter int WIN_CYC   = 2048,
  parameter int THR_W     = 16,
  parameter int LW_W      = 4,
  parameter int PPM_SHIFT = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_edge,
  input  logic             fb_edge,
  input  logic             los_i,
  input  logic             pause_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [LW_W-1:0]  lock_win_i,
  output logic             lol_o,
  output logic             cal_o
);
  localparam int CNT_W  = $clog2(WIN_CYC + 1);
  localparam int WCNT_W = $clog2(WIN_CYC);
  localparam int PROD_W = CNT_W + THR_W;

  lol_state_t         state_q;
  logic [WCNT_W-1:0]  win_q;
  logic [CNT_W-1:0]   ref_cnt, fb_cnt;
  logic [LW_W-1:0]    good_q;
  logic               lol_q;

  logic               win_end;
  logic [CNT_W-1:0]   diff;
  logic [PROD_W-1:0]  limit;
  logic               win_bad;
  logic [LW_W:0]      need;
  logic [LW_W:0]      good_nx;

  always_comb begin
    win_end = (win_q == WCNT_W'(WIN_CYC - 1));
    diff    = (ref_cnt > fb_cnt) ? (ref_cnt - fb_cnt) : (fb_cnt - ref_cnt);
    limit   = (PROD_W'(ref_cnt) * PROD_W'(thr_i)) >> PPM_SHIFT;
    win_bad = PROD_W'(diff) > limit;
    need    = (lock_win_i == '0) ? (LW_W+1)'(1) : {1'b0, lock_win_i};
    good_nx = {1'b0, good_q} + (LW_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CAL;
      win_q   <= '0;
      ref_cnt <= '0;
      fb_cnt  <= '0;
      good_q  <= '0;
      lol_q   <= 1'b0;
    end else if (pause_i) begin
      state_q <= ST_HOLD;
      win_q   <= '0;
      ref_cnt <= '0;
      fb_cnt  <= '0;
      good_q  <= '0;
    end else if (los_i || state_q == ST_HOLD) begin
      state_q <= ST_CAL;
      if (los_i) lol_q <= 1'b1;
      win_q   <= '0;
      ref_cnt <= '0;
      fb_cnt  <= '0;
      good_q  <= '0;
    end else if (win_end) begin
      win_q   <= '0;
      ref_cnt <= '0;
      fb_cnt  <= '0;
      if (win_bad) begin
        lol_q   <= 1'b1;
        good_q  <= '0;
        state_q <= ST_CAL;
      end else if (state_q == ST_CAL) begin
        if (good_nx >= need) begin
          state_q <= ST_LOCK;
          lol_q   <= 1'b0;
          good_q  <= '0;
        end else begin
          good_q  <= good_nx[LW_W-1:0];
        end
      end
    end else begin
      win_q   <= win_q + WCNT_W'(1);
      ref_cnt <= ref_cnt + CNT_W'(ref_edge);
      fb_cnt  <= fb_cnt + CNT_W'(fb_edge);
    end
  end

  assign lol_o = lol_q;
  assign cal_o = (state_q == ST_CAL);

  p_lock_at_window_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK && $past(state_q) != ST_LOCK) |-> $past(win_end));

  p_pause_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(pause_i) && pause_i) |-> $stable(lol_q));

  p_los_forces_lol_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(los_i) && !$past(pause_i)) |-> lol_q);
endmodule

// File: rtl/clkmon_top.sv
`timescale 1ns/1ps
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int WIN_CYC     = 2048,
  parameter int LOS_SET_CYC = 260,
  parameter int LOS_CLR_CYC = 20,
  parameter int LOS_GAP     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mon_clk,
  input  logic              rst,
  input  logic              ref_clk,
  input  logic              fb_clk,
  input  logic              xtal_lost,
  input  logic              pause,
  input  logic [15:0]       thr,
  input  logic [3:0]        lock_win,
  input  logic [MASK_W-1:0] int_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam int NCLK = 2;

  logic [NCLK-1:0] src_clks;
  logic [NCLK-1:0] edges;
  logic            los, lol, cal;
  logic [MASK_W-1:0] raw;
  logic [STAT_W-1:0] status_q;
  logic              irq_q;

  assign src_clks = {fb_clk, ref_clk};

  for (genvar i = 0; i < NCLK; i++) begin : g_sync
    clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .src_clk(src_clks[i]),
      .clk    (mon_clk),
      .rst    (rst),
      .edge_o (edges[i])
    );
  end

  clkmon_los #(
    .LOS_SET_CYC(LOS_SET_CYC),
    .LOS_CLR_CYC(LOS_CLR_CYC),
    .LOS_GAP    (LOS_GAP)
  ) u_los (
    .clk   (mon_clk),
    .rst   (rst),
    .edge_i(edges[0]),
    .los_o (los)
  );

  clkmon_lol #(
    .WIN_CYC  (WIN_CYC),
    .THR_W    (16),
    .LW_W     (4),
    .PPM_SHIFT(20)
  ) u_lol (
    .clk       (mon_clk),
    .rst       (rst),
    .ref_edge  (edges[0]),
    .fb_edge   (edges[1]),
    .los_i     (los),
    .pause_i   (pause),
    .thr_i     (thr),
    .lock_win_i(lock_win),
    .lol_o     (lol),
    .cal_o     (cal)
  );

  always_comb begin
    raw         = '0;
    raw[B_LOL]  = lol;
    raw[B_LOS]  = los;
    raw[B_XTAL] = xtal_lost;
    raw[B_CAL]  = cal;
  end

  always_ff @(posedge mon_clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= {{(STAT_W-MASK_W){1'b0}}, raw};
      irq_q    <= |(raw & ~int_mask);
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

  p_irq_quiet_r8: assert property (@(posedge mon_clk) disable iff (rst)
    (status_q == '0) |-> !irq_q);

  p_spare_zero_r2: assert property (@(posedge mon_clk) disable iff (rst)
    (status_q[7:5] == 3'b000) && !status_q[1]);
endmodule

// File: tb/clkmon_top_bench.sv
`timescale 1ns/1ps
module clkmon_top_bench;
  localparam real MON_PERIOD = 10.0;
  localparam real REF_HALF   = 15.0;
  localparam int  WIN        = 2048;
  localparam int  LSET       = 260;
  localparam int  LCLR       = 20;

  logic       mon_clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk = 1'b0;
  logic       fb_clk = 1'b0;
  logic       xtal_lost = 1'b0;
  logic       pause = 1'b0;
  logic [15:0] thr = 16'd8192;
  logic [3:0] lock_win = 4'd2;
  logic [4:0] int_mask = 5'd0;
  logic [7:0] status;
  logic       irq;

  logic ref_run = 1'b1;
  real  fb_half = 15.0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  clkmon_top u_clkmon_top (
    .mon_clk(mon_clk), .rst(rst), .ref_clk(ref_clk), .fb_clk(fb_clk),
    .xtal_lost(xtal_lost), .pause(pause), .thr(thr), .lock_win(lock_win),
    .int_mask(int_mask), .status(status), .irq(irq)
  );

  always #(MON_PERIOD/2.0) mon_clk = ~mon_clk;

  always begin
    if (ref_run) begin
      #(REF_HALF) ref_clk = ~ref_clk;
    end else begin
      ref_clk = 1'b0;
      #1;
    end
  end

  always #(fb_half) fb_clk = ~fb_clk;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge mon_clk);
    @(negedge mon_clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected loss-of-lock for a feedback offset in ppm and a threshold in parts per 2^20.
  function automatic int exp_lol(input int dppm, input int th);
    real edges, diff, lim;
    edges = WIN * MON_PERIOD / (2.0 * REF_HALF);
    diff  = edges * dppm / (1.0e6 + dppm);
    lim   = edges * th / 1048576.0;
    return (diff + 1.0 > lim) ? 1 : 0;
  endfunction

  function automatic int exp_irq(input logic [7:0] st, input logic [4:0] m);
    return |(st[4:0] & ~m);
  endfunction

  task automatic set_fb(input int dppm);
    fb_half = REF_HALF * (1.0e6 + dppm) / 1.0e6;
  endtask

  initial begin
    int seed, dppm, e;
    seed = $urandom(32'd4242);
    cyc(5);
    chk("R1 status in reset", int'(status), 0);
    chk("R1 irq in reset", int'(irq), 0);
    rst = 1'b0;
    cyc(4);
    chk("R1 acquiring after reset", int'(status[0]), 1);
    chk("R1 no lol after reset", int'(status[4]), 0);
    chk("R8 irq from cal unmasked", int'(irq), 1);
    int_mask = 5'h01;
    cyc(2);
    chk("R8 masked irq", int'(irq), 0);
    chk("R8 status visible when masked", int'(status[0]), 1);
    int_mask = 5'h00;

    cyc(4*WIN);
    chk("R6 locked lol", int'(status[4]), 0);
    chk("R6 locked cal", int'(status[0]), 0);
    chk("R2 status byte locked", int'(status), 0);
    chk("R8 irq idle", int'(irq), 0);

    xtal_lost = 1'b1;
    cyc(2);
    chk("R2 xtal bit", int'(status), 4);
    chk("R8 irq xtal", int'(irq), 1);
    int_mask = 5'h04;
    cyc(2);
    chk("R8 xtal masked", int'(irq), 0);
    xtal_lost = 1'b0;
    int_mask = 5'h00;

    set_fb(30000);
    cyc(3*WIN);
    chk("R5 lol on 3pct", int'(status[4]), 1);
    chk("R6 reacquire after bad", int'(status[0]), 1);
    chk("R8 irq on lol", int'(irq), exp_irq(status, int_mask));

    set_fb(0);
    cyc(4*WIN);
    chk("R6 relock", int'(status[4]), 0);

    ref_run = 1'b0;
    cyc(LSET - 20);
    chk("R3 no los early", int'(status[3]), 0);
    cyc(30);
    chk("R3 los set", int'(status[3]), 1);
    chk("R9 lol during los", int'(status[4]), 1);
    chk("R9 cal during los", int'(status[0]), 1);
    ref_run = 1'b1;
    cyc(10);
    chk("R4 los held", int'(status[3]), 1);
    cyc(50);
    chk("R4 los cleared", int'(status[3]), 0);
    cyc(4*WIN);
    chk("R9 lock back", int'(status[4]), 0);

    pause = 1'b1;
    set_fb(40000);
    cyc(4*WIN);
    chk("R7 lol frozen", int'(status[4]), 0);
    chk("R7 cal low paused", int'(status[0]), 0);
    pause = 1'b0;
    cyc(4);
    chk("R7 cal after release", int'(status[0]), 1);
    cyc(3*WIN);
    chk("R7 R5 lol after release", int'(status[4]), 1);

    lock_win = 4'd0;
    for (int k = 0; k < 6; k++) begin
      if (($urandom % 2) == 0) dppm = $urandom % 300;
      else dppm = 20000 + ($urandom % 40000);
      if (($urandom % 2) == 0) dppm = -dppm;
      set_fb(dppm);
      cyc(5*WIN);
      e = exp_lol(dppm < 0 ? -dppm : dppm, 8192);
      chk($sformatf("R5 random dppm=%0d", dppm), int'(status[4]), e);
      chk("R6 random cal", int'(status[0]), e);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(MON_PERIOD * 190000.0);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule